// File: doc/BRIEF.md
# Audio Sample Queue Pair with Level Requests

This block sits between a 32-bit register port and an audio serializer. It keeps two first-in, first-out queues of 16-bit samples. The transmit queue is filled by register writes and drained by the serializer. The receive queue is filled by the serializer and drained by register reads. Software or a transfer engine reads one status word to see both fill counts and two level-based request flags. Each flag is compared against its own programmable threshold.

Four sticky error flags record lost or invented samples: a write into a full transmit queue, a serializer pop from an empty transmit queue, a serializer push into a full receive queue, and a register read of an empty receive queue. Request and error conditions each drive an interrupt line through their own enable bits. Each queue can be held in reset on its own, and a one-shot soft reset clears both queues and all flags at once.

Register map (word index on `reg_addr`): 0 control, 1 error flags, 2 status, 3 thresholds, 4 transmit data (write), 5 receive data (read).

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the status word (address 2) reports zero in both count fields and in the receive request flag. The error register (address 1), the threshold register (address 3) and all three interrupt outputs are zero.
- R2: Each queue holds 32 samples and returns them in the order they were written. The transmit count is in status bits 29:24 and the receive count is in status bits 13:8.
- R3: A write to address 4 queues bits 31:16 of the write data. A read of address 5 returns the oldest receive sample in bits 31:16 with bits 15:0 zero. Read data appears on `reg_rdata` one clock after the read strobe.
- R4: The transmit request flag (status bit 16) is set in every cycle in which the transmit count is less than or equal to the transmit threshold (address 3, bits 12:8). Writing status with bit 16 at 0 clears the flag only when that condition is false; writing 1 leaves it unchanged.
- R5: The receive request flag (status bit 0) is set in every cycle in which the receive count is greater than the receive threshold (address 3, bits 4:0). It clears the same way through status bit 0.
- R6: A transmit data write to a full queue is dropped and sets error bit 28. A serializer pop from an empty transmit queue presents 0 on `ser_tx_sample` and sets error bit 29.
- R7: A serializer push into a full receive queue is dropped and sets error bit 26. A register read of an empty receive queue returns 0 and sets error bit 27.
- R8: Error flags stay set until software writes 0 to that bit of address 1. Writing 1 to a bit leaves it unchanged.
- R9: While control bit 0 (transmit) or bit 1 (receive) is 1, that queue's count stays 0, pushes into it are ignored, and its request flag is 0.
- R10: Writing control with bit 2 at 1 empties both queues and clears all error and request flags in that cycle. The other control bits take the written value, and bit 2 always reads 0.
- R11: `irq_tx_req` is the transmit flag ANDed with control bit 3, and `irq_rx_req` is the receive flag ANDed with control bit 4. `irq_err` is 1 when any error bit is set whose control bit at the same position (29 to 26) is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| ser_tx_pop | input | 1 | Serializer takes one transmit sample |
| ser_tx_sample | output | 16 | Oldest transmit sample, 0 when the queue is empty |
| ser_rx_push | input | 1 | Serializer delivers one receive sample |
| ser_rx_sample | input | 16 | Sample delivered with `ser_rx_push` |
| irq_tx_req | output | 1 | Enabled transmit request |
| irq_rx_req | output | 1 | Enabled receive request |
| irq_err | output | 1 | Any enabled sticky error |

## Verification
The assertions assume that the register port never writes and reads in the same cycle, and that addresses beyond 5 carry no meaning beyond reading zero. They also assume that a push or pop strobe stands for exactly one sample in the cycle it is high. The stimulus issues one operation at a time, with a quiet cycle after each, so that every flag update can be tied to a single count change. The random phase never raises the per-queue reset holds; those are driven only in directed steps whose effect is read back through the status word.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam int QDEPTH   = 32;
  localparam int THR_W    = 5;
  localparam int CNT_W    = $clog2(QDEPTH + 1);
  localparam int FIELD_W  = 6;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_ERR  = 3'd1,
    A_STAT = 3'd2,
    A_THR  = 3'd3,
    A_TXD  = 3'd4,
    A_RXD  = 3'd5
  } reg_addr_e;

  // control bits
  localparam int B_TXQ_HOLD = 0;
  localparam int B_RXQ_HOLD = 1;
  localparam int B_SOFT_RST = 2;
  localparam int B_TXREQ_EN = 3;
  localparam int B_RXREQ_EN = 4;
  // error bits (enable bits share the same positions in control)
  localparam int B_TX_UF = 29;
  localparam int B_TX_OF = 28;
  localparam int B_RX_UF = 27;
  localparam int B_RX_OF = 26;
  // status fields
  localparam int B_TX_CNT = 24;
  localparam int B_TX_REQ = 16;
  localparam int B_RX_CNT = 8;
  localparam int B_RX_REQ = 0;
  // threshold fields
  localparam int B_TX_THR = 8;
  localparam int B_RX_THR = 0;

  localparam logic [WORD_W-1:0] ERR_MASK =
    (32'd1 << B_TX_UF) | (32'd1 << B_TX_OF) | (32'd1 << B_RX_UF) | (32'd1 << B_RX_OF);
  localparam logic [WORD_W-1:0] CTRL_MASK =
    ERR_MASK | (32'd1 << B_TXQ_HOLD) | (32'd1 << B_RXQ_HOLD) |
    (32'd1 << B_TXREQ_EN) | (32'd1 << B_RXREQ_EN);

  function automatic logic tx_wants(input logic [CNT_W-1:0] cnt, input logic [THR_W-1:0] thr);
    return cnt <= CNT_W'(thr);
  endfunction

  function automatic logic rx_ready(input logic [CNT_W-1:0] cnt, input logic [THR_W-1:0] thr);
    return cnt > CNT_W'(thr);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [CNT_W-1:0] tc, input logic tf,
                                                     input logic [CNT_W-1:0] rc, input logic rf);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_TX_CNT +: FIELD_W] = FIELD_W'(tc);
    w[B_TX_REQ]            = tf;
    w[B_RX_CNT +: FIELD_W] = FIELD_W'(rc);
    w[B_RX_REQ]            = rf;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_thr(input logic [THR_W-1:0] t, input logic [THR_W-1:0] r);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_TX_THR +: THR_W] = t;
    w[B_RX_THR +: THR_W] = r;
    return w;
  endfunction
endpackage

// File: rtl/asf_sample_queue.sv
module asf_sample_queue #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_drop,
  output logic          pop_empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign pop_ok    = pop & ~hold & ~empty;
  assign push_ok   = push & ~hold & (~full | pop_ok);
  assign push_drop = push & ~hold & full & ~pop_ok;
  assign pop_empty = pop & ~hold & empty;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (hold) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> $stable(count));
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));
endmodule

// File: rtl/asf_req_flag.sv
module asf_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic cond,
  input  logic clr_wr,
  input  logic keep_bit,
  output logic flag
);
  logic clr_now;
  assign clr_now = clr_wr & ~keep_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (hold) flag <= 1'b0;
    else           flag <= cond | (flag & ~clr_now);
  end

  p_level_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && cond) |=> flag);
  p_hold_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !flag);
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import asf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                ser_tx_pop,
  output logic [SAMPLE_W-1:0] ser_tx_sample,
  input  logic                ser_rx_push,
  input  logic [SAMPLE_W-1:0] ser_rx_sample,
  output logic                irq_tx_req,
  output logic                irq_rx_req,
  output logic                irq_err
);
  localparam int SHI = WORD_W - SAMPLE_W;

  logic [WORD_W-1:0]   ctrl_q, err_q, err_keep, err_ev;
  logic [THR_W-1:0]    tx_thr, rx_thr;
  logic [CNT_W-1:0]    tx_count, rx_count;
  logic [SAMPLE_W-1:0] rx_head;
  logic                soft_rst, tx_hold, rx_hold;
  logic                tx_push, rx_pop, stat_wr, err_wr;
  logic                tx_drop, tx_under, rx_drop, rx_under;
  logic                tx_flag, rx_flag;

  // register decode
  assign soft_rst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[B_SOFT_RST];
  assign stat_wr  = reg_wr && (reg_addr == A_STAT);
  assign err_wr   = reg_wr && (reg_addr == A_ERR);
  assign tx_push  = reg_wr && (reg_addr == A_TXD);
  assign rx_pop   = reg_rd && (reg_addr == A_RXD);
  assign tx_hold  = ctrl_q[B_TXQ_HOLD] | soft_rst;
  assign rx_hold  = ctrl_q[B_RXQ_HOLD] | soft_rst;

  asf_sample_queue #(.DEPTH(QDEPTH), .DW(SAMPLE_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .hold(tx_hold),
    .push(tx_push), .push_data(reg_wdata[WORD_W-1:SHI]),
    .pop(ser_tx_pop), .head(ser_tx_sample), .count(tx_count),
    .push_drop(tx_drop), .pop_empty(tx_under));

  asf_sample_queue #(.DEPTH(QDEPTH), .DW(SAMPLE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .hold(rx_hold),
    .push(ser_rx_push), .push_data(ser_rx_sample),
    .pop(rx_pop), .head(rx_head), .count(rx_count),
    .push_drop(rx_drop), .pop_empty(rx_under));

  asf_req_flag u_txflag (
    .clk(clk), .rst_n(rst_n), .hold(tx_hold),
    .cond(tx_wants(tx_count, tx_thr)), .clr_wr(stat_wr),
    .keep_bit(reg_wdata[B_TX_REQ]), .flag(tx_flag));

  asf_req_flag u_rxflag (
    .clk(clk), .rst_n(rst_n), .hold(rx_hold),
    .cond(rx_ready(rx_count, rx_thr)), .clr_wr(stat_wr),
    .keep_bit(reg_wdata[B_RX_REQ]), .flag(rx_flag));

  // control and thresholds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
      if (reg_addr == A_THR) begin
        tx_thr <= reg_wdata[B_TX_THR +: THR_W];
        rx_thr <= reg_wdata[B_RX_THR +: THR_W];
      end
    end
  end

  // sticky errors: set wins, write-zero clears
  always_comb begin
    err_ev = '0;
    err_ev[B_TX_OF] = tx_drop;
    err_ev[B_TX_UF] = tx_under;
    err_ev[B_RX_OF] = rx_drop;
    err_ev[B_RX_UF] = rx_under;
    err_keep = err_wr ? reg_wdata : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= '0;
    else if (soft_rst) err_q <= '0;
    else               err_q <= ((err_q & err_keep) | err_ev) & ERR_MASK;
  end

  // read port, one cycle latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_q;
        A_ERR:   reg_rdata <= err_q;
        A_STAT:  reg_rdata <= pack_status(tx_count, tx_flag, rx_count, rx_flag);
        A_THR:   reg_rdata <= pack_thr(tx_thr, rx_thr);
        A_RXD:   reg_rdata <= {rx_head, {SHI{1'b0}}};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign irq_tx_req = tx_flag & ctrl_q[B_TXREQ_EN];
  assign irq_rx_req = rx_flag & ctrl_q[B_RXREQ_EN];
  assign irq_err    = |(err_q & ctrl_q & ERR_MASK);

  p_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  p_rx_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_hold && rx_count == '0) |=> (reg_rdata == '0) && err_q[B_RX_UF]);
  p_tx_overflow_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> err_q[B_TX_OF]);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_wr || soft_rst) |=> ((err_q & $past(err_q)) == $past(err_q)));
  p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_hold && rx_count > CNT_W'(rx_thr)) |=> rx_flag);
  p_soft_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (err_q == '0) && (tx_count == '0) && (rx_count == '0) && !tx_flag && !rx_flag);
endmodule

// File: tb/test_audio_sample_fifo.sv
`timescale 1ns/1ps
module test_audio_sample_fifo;
  import asf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
  logic [15:0] ser_tx_sample, ser_rx_sample = '0;
  logic        irq_tx_req, irq_rx_req, irq_err;

  always #2 clk = ~clk;

  audio_sample_fifo i_audio_sample_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_tx_pop(ser_tx_pop),
    .ser_tx_sample(ser_tx_sample), .ser_rx_push(ser_rx_push), .ser_rx_sample(ser_rx_sample),
    .irq_tx_req(irq_tx_req), .irq_rx_req(irq_rx_req), .irq_err(irq_err));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [15:0] txm[$];
  logic [15:0] rxm[$];
  logic [31:0] err_m = '0, ctrl_m = '0;
  int          thr_t = 0, thr_r = 0;
  bit          txf_m = 0, rxf_m = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit tcond(); return txm.size() <= thr_t; endfunction
  function automatic bit rcond(); return rxm.size() > thr_r; endfunction

  function automatic logic [31:0] exp_status();
    return {2'b00, 6'(txm.size()), 7'b0, txf_m, 2'b00, 6'(rxm.size()), 7'b0, rxf_m};
  endfunction

  task automatic settle();
    if (ctrl_m[0]) txf_m = 0; else txf_m = txf_m | tcond();
    if (ctrl_m[1]) rxf_m = 0; else rxf_m = rxf_m | rcond();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic tx_write(input logic [15:0] s);
    wr(3'd4, {s, 16'($urandom)});
    if (!ctrl_m[0]) begin
      if (txm.size() == QDEPTH) err_m[28] = 1; else txm.push_back(s);
    end
    settle();
  endtask

  task automatic tx_pop(input string req);
    logic [15:0] e;
    e = (txm.size() == 0) ? 16'h0 : txm[0];
    check(req, "ser_tx_sample", {16'h0, ser_tx_sample}, {16'h0, e});
    ser_tx_pop = 1;
    @(negedge clk); ser_tx_pop = 0;
    @(negedge clk);
    if (!ctrl_m[0]) begin
      if (txm.size() == 0) err_m[29] = 1; else void'(txm.pop_front());
    end
    settle();
  endtask

  task automatic rx_push(input logic [15:0] s);
    ser_rx_push = 1; ser_rx_sample = s;
    @(negedge clk); ser_rx_push = 0;
    @(negedge clk);
    if (!ctrl_m[1]) begin
      if (rxm.size() == QDEPTH) err_m[26] = 1; else rxm.push_back(s);
    end
    settle();
  endtask

  task automatic rx_read(input string req);
    logic [31:0] d, e;
    rd(3'd5, d);
    if (ctrl_m[1] || rxm.size() == 0) begin
      e = 32'h0;
      if (!ctrl_m[1]) err_m[27] = 1;
    end else e = {rxm.pop_front(), 16'h0};
    check(req, "rx data word", d, e);
    settle();
  endtask

  task automatic chk_status(input string req);
    logic [31:0] d;
    rd(3'd2, d);
    check(req, "status", d, exp_status());
    settle();
  endtask

  task automatic chk_err(input string req);
    logic [31:0] d;
    rd(3'd1, d);
    check(req, "errors", d, err_m);
  endtask

  task automatic chk_irq(input string req);
    check(req, "irq lines", {29'h0, irq_tx_req, irq_rx_req, irq_err},
          {29'h0, txf_m & ctrl_m[3], rxf_m & ctrl_m[4], |(err_m & ctrl_m)});
  endtask

  task automatic set_thr(input int t, input int r);
    wr(3'd3, (32'(t) << 8) | 32'(r));
    thr_t = t; thr_r = r;
    settle();
  endtask

  task automatic clr_flags(input logic [31:0] d);
    wr(3'd2, d);
    txf_m = ctrl_m[0] ? 1'b0 : ((txf_m & d[16]) | tcond());
    rxf_m = ctrl_m[1] ? 1'b0 : ((rxf_m & d[0]) | rcond());
    settle();
  endtask

  task automatic clr_err(input logic [31:0] d);
    wr(3'd1, d);
    err_m = err_m & d;
    settle();
  endtask

  task automatic set_ctrl(input logic [31:0] d);
    wr(3'd0, d);
    ctrl_m = d & CTRL_MASK;
    if (d[2]) begin
      txm.delete(); rxm.delete(); err_m = '0; txf_m = 0; rxf_m = 0;
    end
    if (ctrl_m[0]) txm.delete();
    if (ctrl_m[1]) rxm.delete();
    settle();
  endtask

  initial begin
    #700000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd90210));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    settle();

    // R1 reset state
    chk_status("R1");
    chk_err("R1");
    rd(3'd3, d); check("R1", "thresholds", d, 32'h0);
    chk_irq("R1");

    // R2/R3 ordering and alignment
    tx_write(16'h1234); tx_write(16'hBEEF); tx_write(16'h0F0F);
    chk_status("R2");
    tx_pop("R3"); tx_pop("R2"); tx_pop("R2");

    // R6 transmit overflow and underflow
    for (int i = 0; i < QDEPTH; i++) tx_write(16'(i * 3 + 1));
    chk_status("R2");
    tx_write(16'hDEAD);
    chk_err("R6");
    chk_status("R6");
    for (int i = 0; i < QDEPTH; i++) tx_pop("R6");
    tx_pop("R6");
    chk_err("R6");

    // R7 receive overflow and underflow
    for (int i = 0; i <= QDEPTH; i++) rx_push(16'(16'hA000 + i));
    chk_status("R7");
    chk_err("R7");
    for (int i = 0; i <= QDEPTH; i++) rx_read("R7");
    chk_err("R7");

    // R8 selective clearing
    clr_err(32'hEFFF_FFFF);
    chk_err("R8");
    clr_err(32'h0);
    chk_err("R8");

    // R4 transmit threshold
    set_thr(15, 3);
    for (int i = 0; i < 16; i++) tx_write(16'(i));
    clr_flags(32'h0);
    chk_status("R4");
    tx_pop("R4");
    chk_status("R4");
    clr_flags(32'h0);
    chk_status("R4");
    while (txm.size() > 0) tx_pop("R4");

    // R5 receive threshold
    for (int i = 0; i < 3; i++) rx_push(16'(i + 7));
    chk_status("R5");
    rx_push(16'h5555);
    chk_status("R5");
    for (int i = 0; i < 4; i++) rx_read("R5");
    clr_flags(32'h0001_0000);
    chk_status("R5");

    // R11 interrupt enables
    set_ctrl(32'h3C00_0018);
    chk_irq("R11");
    tx_pop("R11");
    chk_irq("R11");
    set_ctrl(32'h2000_0000);
    chk_irq("R11");
    clr_err(32'h0);
    chk_irq("R11");

    // R9 queue holds
    set_ctrl(32'h0000_0003);
    chk_status("R9");
    tx_write(16'h7777);
    rx_push(16'h8888);
    chk_status("R9");
    chk_err("R9");
    set_ctrl(32'h0);
    chk_status("R9");

    // R10 soft reset
    tx_write(16'h1111); rx_push(16'h2222); rx_push(16'h3333); tx_pop("R10"); tx_pop("R10");
    set_ctrl(32'h0400_0014);
    chk_status("R10");
    chk_err("R10");
    rd(3'd0, d); check("R10", "control readback", d, ctrl_m);
    set_ctrl(32'h0);
    set_thr(0, 0);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0, 1, 2: tx_write(16'($urandom));
        3, 4:    tx_pop("R2");
        5, 6, 7: rx_push(16'($urandom));
        8, 9:    rx_read("R3");
        10: begin
          int k;
          k = $urandom_range(0, 3);
          if (k == 0) set_thr($urandom_range(0, 31), $urandom_range(0, 31));
          else if (k == 1) clr_flags($urandom);
          else if (k == 2) clr_err($urandom);
          else chk_err("R8");
        end
        default: chk_status("R4");
      endcase
      if (n % 16 == 0) chk_status("R5");
    end
    chk_err("R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule